// File: doc/BRIEF.md
# Watchdog Countdown with Two-Way Mailbox

This block is a byte-wide register file that holds a reloadable watchdog down-counter and two 8-bit mailboxes. Normal operating software and a system-management handler use the mailboxes to exchange messages. The counter moves down by one on each pulse of a slow tick input, which is generated outside the block. Software restarts the countdown by writing to a reload offset. If software lets the countdown run out, the block emits a one-cycle timeout pulse and records the event in a sticky status bit.

Each mailbox write has a side effect:

- A message for the management handler (inbound) sets a status flag and fires a single-cycle management-interrupt request.
- A message for the operating software (outbound) sets a different status flag. That flag holds one of four host-interrupt lines high, and a 2-bit routing field chooses which line.

The restart value is programmable, but values below four ticks are refused. This enforces a minimum timeout.

The register offsets are:

| Offset | Register | Notes |
|---|---|---|
| 0 | Reload trigger | A write restarts the countdown. A read returns the live count. |
| 1 | Restart value | 6-bit value, bits 7:6 read zero. |
| 2 | Inbound mailbox | Message for the management handler. |
| 3 | Outbound mailbox | Message for the operating software. |
| 4 | Status | Write 1 to clear. |
| 5 | Interrupt routing | 2-bit line select. |

Top module: `wdog_mbox`

## Requirements
- R1: After synchronous active-high reset, the block is in this state:
  - offset 1 reads 04h and offset 0 reads 04h;
  - offsets 2, 3, 4 and 5 read 00h;
  - timeoutPulse, mgmtIrq and all hostIrq lines are low.
- R2: A write to offset 1 stores write-data bits 5:0 as the restart value. Bits 7:6 of offset 1 always read zero.
- R3: A write to offset 1 whose bits 5:0 hold 0, 1, 2 or 3 leaves the stored restart value unchanged. A value of 4 is accepted.
- R4: A write to offset 0 copies the restart value into the counter, whatever the write data. A read of offset 0 returns the current count.
- R5: A slowTick while the count is nonzero lowers the count by one.
- R6: A slowTick while the count is zero has three effects:
  - timeoutPulse is high for exactly the following cycle;
  - status bit 0 is set and stays set;
  - the counter reloads from the restart value.
- R7: A write to offset 2 stores the byte and sets status bit 1. mgmtIrq is high in the following cycle only, unless another offset-2 write follows.
- R8: A write to offset 3 stores the byte and sets status bit 2. While bit 2 is set, hostIrq[n] is high for n equal to the routing field, and every other hostIrq line is low.
- R9: A write to offset 4 clears each status bit whose write-data bit is 1 and leaves the others alone. An event that sets a bit in the same cycle wins over the clear.
- R10: If a write to offset 0 and a slowTick happen in the same cycle, the counter loads the restart value and the tick has no effect.
- R11: A write to offset 5 stores bits 1:0 as the routing field, and bits 7:2 read zero. Offsets 6 and 7 read 00h, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr (combinational) |
| slowTick | input | 1 | One-cycle countdown tick |
| timeoutPulse | output | 1 | One-cycle watchdog expiry pulse |
| mgmtIrq | output | 1 | Management-interrupt request pulse |
| hostIrq | output | 4 | Host-interrupt lines, one selected by the routing field |

## Verification
The bench builds the block with its default parameters:

- a 6-bit counter;
- a floor of 4;
- a reset value of 4;
- a 2-bit routing field.

With these values, every restart value from the floor up to 63 is reachable. Because slowTick is an ordinary per-cycle input in the bench, a full expiry from any count takes at most 64 cycles. Expiry, reload-versus-tick collisions and set-versus-clear collisions can therefore all be driven many times within the run. All four host lines are reachable through the 2-bit routing field.

// File: rtl/wdog_mbox_pkg.sv
package wdog_mbox_pkg;

  // Register offsets (the bench and software decode these)
  localparam int OFS_RELOAD = 0;
  localparam int OFS_INIT   = 1;
  localparam int OFS_DIN    = 2;
  localparam int OFS_DOUT   = 3;
  localparam int OFS_STS    = 4;
  localparam int OFS_SEL    = 5;

  // Status bit positions
  localparam int STS_TIMEOUT = 0;
  localparam int STS_SWMGMT  = 1;
  localparam int STS_DOUT    = 2;
  localparam int STS_W       = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic reload;
    logic initWr;
    logic dinWr;
    logic doutWr;
    logic stsWr;
    logic selWr;
    logic tickCount;
  } wd_strobe_t;

endpackage

// File: rtl/wdog_mbox_ctrl.sv
module wdog_mbox_ctrl
  import wdog_mbox_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              slowTick,
  output wd_strobe_t        stb
);

  always_comb begin
    stb = '0;
    if (regWrEn) begin
      stb.reload = (regAddr == ADDR_W'(OFS_RELOAD));
      stb.initWr = (regAddr == ADDR_W'(OFS_INIT));
      stb.dinWr  = (regAddr == ADDR_W'(OFS_DIN));
      stb.doutWr = (regAddr == ADDR_W'(OFS_DOUT));
      stb.stsWr  = (regAddr == ADDR_W'(OFS_STS));
      stb.selWr  = (regAddr == ADDR_W'(OFS_SEL));
    end
    // A reload access swallows a tick arriving in the same cycle
    stb.tickCount = slowTick && !stb.reload;
  end

  // R11: at most one register is written per access
  p_one_target_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stb.reload, stb.initWr, stb.dinWr, stb.doutWr, stb.stsWr, stb.selWr}));

  // R11: no strobe without a write
  p_no_write_idle_r11: assert property (@(posedge clk) disable iff (rst)
    !regWrEn |-> !(stb.reload || stb.initWr || stb.dinWr || stb.doutWr || stb.stsWr || stb.selWr));

endmodule

// File: rtl/wdog_mbox_dp.sv
module wdog_mbox_dp
  import wdog_mbox_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 6,
  parameter int SEL_W    = 2,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  wd_strobe_t           stb,
  input  logic [ADDR_W-1:0]    rdAddr,
  input  logic [DATA_W-1:0]    wrData,
  output logic [DATA_W-1:0]    rdData,
  output logic                 timeoutPulse,
  output logic                 mgmtIrq,
  output logic [(1<<SEL_W)-1:0] hostIrq
);

  localparam int N_HOST = 1 << SEL_W;

  logic [CNT_W-1:0]  cntQ;
  logic [CNT_W-1:0]  initQ;
  logic [DATA_W-1:0] dinQ;
  logic [DATA_W-1:0] doutQ;
  logic [STS_W-1:0]  stsQ;
  logic [SEL_W-1:0]  selQ;
  logic              toPulseQ;
  logic              mgmtQ;

  logic              cntZero;
  logic              expire;
  logic              initOk;
  logic [STS_W-1:0]  stsSet;
  logic [STS_W-1:0]  stsClr;

  always_comb begin
    cntZero = (cntQ == '0);
    expire  = stb.tickCount && cntZero;
    initOk  = (wrData[CNT_W-1:0] >= CNT_W'(MIN_INIT));
    stsSet  = '0;
    stsSet[STS_TIMEOUT] = expire;
    stsSet[STS_SWMGMT]  = stb.dinWr;
    stsSet[STS_DOUT]    = stb.doutWr;
    stsClr  = stb.stsWr ? wrData[STS_W-1:0] : '0;
  end

  // Countdown
  always_ff @(posedge clk) begin
    if (rst) begin
      cntQ     <= CNT_W'(RST_INIT);
      toPulseQ <= 1'b0;
    end else begin
      toPulseQ <= expire;
      if (stb.reload) begin
        cntQ <= initQ;
      end else if (stb.tickCount) begin
        if (cntZero) cntQ <= initQ;
        else         cntQ <= cntQ - CNT_W'(1);
      end
    end
  end

  // Configuration and mailboxes
  always_ff @(posedge clk) begin
    if (rst) begin
      initQ <= CNT_W'(RST_INIT);
      dinQ  <= '0;
      doutQ <= '0;
      selQ  <= '0;
      mgmtQ <= 1'b0;
    end else begin
      mgmtQ <= stb.dinWr;
      if (stb.initWr && initOk) initQ <= wrData[CNT_W-1:0];
      if (stb.dinWr)            dinQ  <= wrData;
      if (stb.doutWr)           doutQ <= wrData;
      if (stb.selWr)            selQ  <= wrData[SEL_W-1:0];
    end
  end

  // Status: set wins over write-1-to-clear
  always_ff @(posedge clk) begin
    if (rst) stsQ <= '0;
    else     stsQ <= (stsQ & ~stsClr) | stsSet;
  end

  // Host interrupt routing
  for (genvar i = 0; i < N_HOST; i++) begin : g_host
    assign hostIrq[i] = stsQ[STS_DOUT] && (selQ == SEL_W'(i));
  end

  // Read mux
  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_W'(OFS_RELOAD): rdData = DATA_W'(cntQ);
      ADDR_W'(OFS_INIT):   rdData = DATA_W'(initQ);
      ADDR_W'(OFS_DIN):    rdData = dinQ;
      ADDR_W'(OFS_DOUT):   rdData = doutQ;
      ADDR_W'(OFS_STS):    rdData = DATA_W'(stsQ);
      ADDR_W'(OFS_SEL):    rdData = DATA_W'(selQ);
      default:             rdData = '0;
    endcase
  end

  assign timeoutPulse = toPulseQ;
  assign mgmtIrq      = mgmtQ;

  // R3: restart value never drops below the floor
  p_init_floor_r3: assert property (@(posedge clk) disable iff (rst)
    initQ >= CNT_W'(MIN_INIT));

  // R5: a counted tick on a nonzero count steps down by one
  p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stb.tickCount) && ($past(cntQ) != '0))
      |-> (cntQ == $past(cntQ) - CNT_W'(1)));

  // R6: expiry pulse lasts one cycle and leaves the sticky bit set
  p_timeout_single_r6: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |=> !timeoutPulse);
  p_timeout_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    timeoutPulse |-> stsQ[STS_TIMEOUT]);

  // R7: a management request always coincides with its status flag
  p_mgmt_flag_r7: assert property (@(posedge clk) disable iff (rst)
    mgmtIrq |-> stsQ[STS_SWMGMT]);

  // R8: exactly one host line is high while outbound status is set
  p_host_one_r8: assert property (@(posedge clk) disable iff (rst)
    $countones(hostIrq) == (stsQ[STS_DOUT] ? 1 : 0));

  // R10: a reload access loads the restart value, tick or not
  p_reload_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stb.reload)) |-> (cntQ == $past(initQ)));

endmodule

// File: rtl/wdog_mbox.sv
module wdog_mbox
  import wdog_mbox_pkg::*;
#(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int CNT_W    = 6,
  parameter int SEL_W    = 2,
  parameter int MIN_INIT = 4,
  parameter int RST_INIT = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [DATA_W-1:0]     regWrData,
  output logic [DATA_W-1:0]     regRdData,
  input  logic                  slowTick,
  output logic                  timeoutPulse,
  output logic                  mgmtIrq,
  output logic [(1<<SEL_W)-1:0] hostIrq
);

  wd_strobe_t stb;

  wdog_mbox_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .regAddr  (regAddr),
    .regWrEn  (regWrEn),
    .slowTick (slowTick),
    .stb      (stb)
  );

  wdog_mbox_dp #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .CNT_W    (CNT_W),
    .SEL_W    (SEL_W),
    .MIN_INIT (MIN_INIT),
    .RST_INIT (RST_INIT)
  ) i_dp (
    .clk          (clk),
    .rst          (rst),
    .stb          (stb),
    .rdAddr       (regAddr),
    .wrData       (regWrData),
    .rdData       (regRdData),
    .timeoutPulse (timeoutPulse),
    .mgmtIrq      (mgmtIrq),
    .hostIrq      (hostIrq)
  );

endmodule

// File: tb/test_wdog_mbox.sv
`timescale 1ns/1ps
module test_wdog_mbox;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] regAddr = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic       slowTick = 1'b0;
  logic       timeoutPulse;
  logic       mgmtIrq;
  logic [3:0] hostIrq;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // Reference model state
  int mCnt, mInit, mDin, mDout, mSts, mSel;
  int mTo, mMgmt;

  always #5 clk = ~clk;

  wdog_mbox i_wdog_mbox (
    .clk(clk), .rst(rst), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .slowTick(slowTick),
    .timeoutPulse(timeoutPulse), .mgmtIrq(mgmtIrq), .hostIrq(hostIrq)
  );

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mRead(int a);
    case (a)
      0: return mCnt;
      1: return mInit;
      2: return mDin;
      3: return mDout;
      4: return mSts;
      5: return mSel;
      default: return 0;
    endcase
  endfunction

  function automatic int mHost();
    return ((mSts >> 2) & 1) ? (1 << mSel) : 0;
  endfunction

  function automatic string rdTag(int a);
    case (a)
      0: return "R4";
      1: return "R2";
      2: return "R7";
      3: return "R8";
      4: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic modelReset();
    mCnt = 4; mInit = 4; mDin = 0; mDout = 0; mSts = 0; mSel = 0;
    mTo = 0; mMgmt = 0;
  endtask

  // One clock: drive, compare every output, advance model
  task automatic step(int a, bit we, int d, bit t);
    int nCnt, nInit, nDin, nDout, nSts, nSel, clr, ev;
    regAddr = a[2:0]; regWrEn = we; regWrData = d[7:0]; slowTick = t;
    #1;
    chk(rdTag(a), int'(regRdData), mRead(a));
    chk("R6", int'(timeoutPulse), mTo);
    chk("R7", int'(mgmtIrq), mMgmt);
    chk("R8", int'(hostIrq), mHost());
    nCnt = mCnt; nInit = mInit; nDin = mDin; nDout = mDout; nSel = mSel; ev = 0;
    if (we && a == 0) nCnt = mInit;
    else if (t) begin
      if (mCnt == 0) begin nCnt = mInit; ev = 1; end
      else nCnt = mCnt - 1;
    end
    if (we && a == 1 && (d & 63) >= 4) nInit = d & 63;
    if (we && a == 2) nDin = d & 255;
    if (we && a == 3) nDout = d & 255;
    if (we && a == 5) nSel = d & 3;
    clr = (we && a == 4) ? (d & 7) : 0;
    nSts = (mSts & ~clr) | ev | ((we && a == 2) ? 2 : 0) | ((we && a == 3) ? 4 : 0);
    @(posedge clk);
    mTo = ev; mMgmt = (we && a == 2) ? 1 : 0;
    mCnt = nCnt; mInit = nInit; mDin = nDin; mDout = nDout; mSts = nSts; mSel = nSel;
    @(negedge clk);
  endtask

  task automatic peek(int a, int exp, string tag);
    regAddr = a[2:0]; regWrEn = 0; slowTick = 0;
    #1;
    chk(tag, int'(regRdData), exp);
    step(a, 0, 0, 0);
  endtask

  task automatic doReset();
    rst = 1; regWrEn = 0; slowTick = 0;
    @(posedge clk); @(posedge clk);
    modelReset();
    @(negedge clk);
    rst = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
      $finish;
    end
  end

  initial begin
    modelReset();
    @(negedge clk);
    doReset();

    // R1 reset values
    chk("R1", int'(timeoutPulse), 0);
    chk("R1", int'(mgmtIrq), 0);
    chk("R1", int'(hostIrq), 0);
    peek(1, 8'h04, "R1");
    peek(0, 8'h04, "R1");
    peek(2, 0, "R1"); peek(3, 0, "R1"); peek(4, 0, "R1"); peek(5, 0, "R1");

    // R2 reserved bits read zero
    step(1, 1, 8'hFF, 0);
    peek(1, 8'h3F, "R2");

    // R3 refused values and boundary
    step(1, 1, 8'h02, 0);
    peek(1, 8'h3F, "R3");
    step(1, 1, 8'hC3, 0);
    peek(1, 8'h3F, "R3");
    step(1, 1, 8'h04, 0);
    peek(1, 8'h04, "R3");

    // R4 reload ignores its data
    step(1, 1, 8'h05, 0);
    step(0, 1, 8'hAA, 0);
    peek(0, 5, "R4");

    // R5 countdown
    step(0, 0, 0, 1); step(0, 0, 0, 1); step(0, 0, 0, 1);
    peek(0, 2, "R5");

    // R6 expiry
    step(0, 0, 0, 1); step(0, 0, 0, 1);
    peek(0, 0, "R5");
    step(0, 0, 0, 1);
    chk("R6", int'(timeoutPulse), 1);
    peek(0, 5, "R6");
    chk("R6", int'(timeoutPulse), 0);
    peek(4, 1, "R6");

    // R9 write-1-to-clear
    step(4, 1, 8'h01, 0);
    peek(4, 0, "R9");

    // R7 inbound mailbox
    step(2, 1, 8'h5A, 0);
    chk("R7", int'(mgmtIrq), 1);
    peek(2, 8'h5A, "R7");
    chk("R7", int'(mgmtIrq), 0);
    peek(4, 2, "R7");

    // R11 routing field, R8 outbound mailbox
    step(5, 1, 8'hFE, 0);
    peek(5, 2, "R11");
    step(3, 1, 8'h77, 0);
    chk("R8", int'(hostIrq), 4'b0100);
    peek(3, 8'h77, "R8");
    step(5, 1, 8'h01, 0);
    chk("R8", int'(hostIrq), 4'b0010);
    step(4, 1, 8'h02, 0);
    chk("R9", int'(hostIrq), 4'b0010);
    peek(4, 4, "R9");
    step(4, 1, 8'h04, 0);
    chk("R8", int'(hostIrq), 0);

    // R9 set beats clear in the same cycle
    step(1, 1, 8'h04, 0);
    step(0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 1);
    peek(0, 0, "R9");
    step(4, 1, 8'h01, 1);
    peek(4, 1, "R9");

    // R10 reload beats tick
    step(0, 0, 0, 1);
    peek(0, 3, "R10");
    step(0, 1, 8'h00, 1);
    peek(0, 4, "R10");

    // R11 unmapped offsets
    step(6, 1, 8'hFF, 0);
    step(7, 1, 8'hFF, 0);
    peek(6, 0, "R11");
    peek(7, 0, "R11");
    peek(1, 4, "R11");

    // Mixed traffic compared against the model on every clock
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      bit we, t;
      a  = int'($urandom_range(0, 7));
      we = ($urandom_range(0, 3) == 0);
      d  = int'($urandom_range(0, 255));
      t  = ($urandom_range(0, 1) == 1);
      if (a == 0 && we && $urandom_range(0, 3) != 0) we = 0;
      step(a, we, d, t);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule